// File: doc/BRIEF.md
# Two-Level Interrupt Gate Controller

This block routes level-sensitive interrupt sources to a small set of processor cores. A source reaches a core only after passing two independent gates. The first gate is a single global enable bit per source. The second is per core: each core keeps its own mask bit for every source, and each source has a routing field that lists the cores allowed to receive it. Software changes the global enables and the per-core masks by writing the number of a source to a set register or a clear register, so no read-modify-write of a bitmap is ever needed.

Every bus access carries the number of the core that issues it. The mask, unmask and acknowledge registers all act on the registers of that core, so each core reaches its own copy at the same offsets. Reading the acknowledge register returns the lowest-numbered source that currently qualifies for the reading core, or the all-ones code 1023 when none does. Each core also has an IRQ output that is high while any source qualifies for it. Reads have no side effects; a source stays pending for as long as its input is held high.

Top module: `dual_gate_intc`

## Requirements
- R1: After reset, every global enable is clear, every per-core mask bit is set and every routing field is zero. As a result all IRQ outputs are low and every acknowledge read returns 1023, even once sources are asserted, enabled and routed, until a core unmasks them.
- R2: A read at offset 0x000 returns the number of implemented sources in bits [11:2], with all other bits zero.
- R3: Writing a source number n to offset 0x030 sets the global enable of source n. Writing n to offset 0x034 clears it. The change is visible on the IRQ outputs one cycle after the write edge.
- R4: Writing a source number n to offset 0x048 sets the mask of source n for the core named on the bus for that access only. Writing n to offset 0x04C clears that mask bit. The masks of the other cores are unchanged.
- R5: The routing register of source n sits at offset 0x100 + 4*n. Bit c of it (for c below the core count) allows core c to receive source n. A read returns those bits, and every higher bit of the written value is dropped and reads as zero.
- R6: A source number equal to or above the source count is ignored. This holds for a written data value (any of its 32 bits) and for a routing address past the last source, and the state of every existing source stays unchanged.
- R7: Source n qualifies for core c only when its input is high, its global enable is set, bit c of its routing field is set and core c has not masked it. The IRQ output of core c is high one cycle after any source qualifies for c, and low one cycle after none does.
- R8: A read at offset 0x044 returns, in bits [9:0], the lowest-numbered source that qualifies for the reading core, and 1023 when none qualifies. The upper bits are zero.
- R9: Sources are level sensitive and acknowledge reads have no side effects. A repeated read returns the same number, and lowering a source input removes it from the acknowledge result and from the IRQ output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Write strobe for one cycle |
| busRd | input | 1 | Read strobe for one cycle |
| busAddr | input | ADDR_W (12) | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busCore | input | 2 | Number of the core issuing the access |
| busRdData | output | 32 | Read data, valid from the edge that takes busRd |
| srcIn | input | NUM_SRC (64) | Level-sensitive interrupt inputs |
| coreIrq | output | NUM_CORE (4) | Interrupt request per core |

## Verification
The state registers change on the edge that takes a write. The IRQ outputs are registered one more time, so they reflect a write two edges after it is driven: one edge to update the state and one to update the output. A change on srcIn reaches the IRQ outputs on the next edge. Read data is registered on the edge that takes busRd and is computed from the state and inputs as they stand just before that edge. The bench drives every input and samples every output on the falling edge. After any write or source change it waits one more falling edge before it compares the IRQ outputs and reads the acknowledge register of every core against a model built from the requirements.

// File: rtl/dgi_pkg.sv
package dgi_pkg;

  // Source numbers are 10 bits wide on the bus; 1023 is reserved for "none".
  localparam int IDX_W     = 10;
  localparam int CORE_W    = 2;
  localparam int MAX_CORES = 4;

  localparam logic [IDX_W-1:0] NONE_PENDING = '1;

  // Byte offsets decoded by the bus front end.
  localparam int OFS_INFO     = 'h000;
  localparam int OFS_EN_SET   = 'h030;
  localparam int OFS_EN_CLR   = 'h034;
  localparam int OFS_ACK      = 'h044;
  localparam int OFS_MASK_SET = 'h048;
  localparam int OFS_MASK_CLR = 'h04C;
  localparam int OFS_ROUTE    = 'h100;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_INFO  = 2'd1,
    RD_ACK   = 2'd2,
    RD_ROUTE = 2'd3
  } rdSel_e;

  // Strobes handed from the decoder to the gate datapath.
  typedef struct packed {
    logic                 setEn;
    logic                 clrEn;
    logic                 setMask;
    logic                 clrMask;
    logic                 routeWr;
    logic                 rdEn;
    rdSel_e               rdSel;
    logic [IDX_W-1:0]     idx;
    logic [CORE_W-1:0]    coreId;
    logic [MAX_CORES-1:0] routeBits;
  } strobe_t;

endpackage

// File: rtl/dgi_bus_decode.sv
module dgi_bus_decode
  import dgi_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic [1:0]        busCore,
  output strobe_t           strb
);

  localparam logic [ADDR_W:0] ROUTE_LO = (ADDR_W+1)'(OFS_ROUTE);
  localparam logic [ADDR_W:0] ROUTE_HI = (ADDR_W+1)'(OFS_ROUTE + 4*NUM_SRC);

  logic inRoute;
  logic dataIdxOk;

  // Routing window: word-aligned and below the last implemented source.
  assign inRoute = ({1'b0, busAddr} >= ROUTE_LO) &&
                   ({1'b0, busAddr} <  ROUTE_HI) &&
                   (busAddr[1:0] == 2'b00);

  // A source number carried in data must have no bits above the index field.
  assign dataIdxOk = (busWrData[31:IDX_W] == '0);

  always_comb begin
    strb           = '0;
    strb.rdSel     = RD_NONE;
    strb.coreId    = CORE_W'(busCore);
    strb.routeBits = busWrData[MAX_CORES-1:0];
    strb.rdEn      = busRd;
    if (inRoute) begin
      strb.idx = IDX_W'((busAddr - ADDR_W'(OFS_ROUTE)) >> 2);
    end else begin
      strb.idx = busWrData[IDX_W-1:0];
    end

    if (busWr) begin
      if (inRoute) begin
        strb.routeWr = 1'b1;
      end else if (dataIdxOk) begin
        case (busAddr)
          ADDR_W'(OFS_EN_SET):   strb.setEn   = 1'b1;
          ADDR_W'(OFS_EN_CLR):   strb.clrEn   = 1'b1;
          ADDR_W'(OFS_MASK_SET): strb.setMask = 1'b1;
          ADDR_W'(OFS_MASK_CLR): strb.clrMask = 1'b1;
          default: ;
        endcase
      end
    end

    if (busRd) begin
      if (busAddr == ADDR_W'(OFS_INFO))     strb.rdSel = RD_INFO;
      else if (busAddr == ADDR_W'(OFS_ACK)) strb.rdSel = RD_ACK;
      else if (inRoute)                     strb.rdSel = RD_ROUTE;
      else                                  strb.rdSel = RD_NONE;
    end
  end

endmodule

// File: rtl/dgi_gate_core.sv
module dgi_gate_core
  import dgi_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CORE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strb,
  input  logic [NUM_SRC-1:0]  srcIn,
  output logic [NUM_CORE-1:0] coreIrq,
  output logic [31:0]         rdData
);

  localparam logic [IDX_W:0] SRC_LIMIT = (IDX_W+1)'(NUM_SRC);

  logic                idxOk;
  logic [NUM_SRC-1:0]  selOh;
  logic [NUM_SRC-1:0]  enReg;
  logic [NUM_SRC-1:0]  maskReg  [NUM_CORE];
  logic [NUM_CORE-1:0] routeReg [NUM_SRC];
  logic [NUM_SRC-1:0]  routeCol [NUM_CORE];
  logic [NUM_SRC-1:0]  qual     [NUM_CORE];
  logic [IDX_W-1:0]    ackIdx   [NUM_CORE];
  logic [IDX_W-1:0]    ackSel;
  logic [NUM_CORE-1:0] routeRd;

  assign idxOk = ({1'b0, strb.idx} < SRC_LIMIT);

  // One-hot select of the addressed source (all zero when out of range).
  genvar gs;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : g_sel
      assign selOh[gs] = idxOk && (strb.idx == IDX_W'(gs));
    end
  endgenerate

  // Global enable gate.
  always_ff @(posedge clk) begin
    if (rst) begin
      enReg <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (strb.setEn && selOh[s])      enReg[s] <= 1'b1;
        else if (strb.clrEn && selOh[s]) enReg[s] <= 1'b0;
      end
    end
  end

  // Per-core mask gate, touched only for the core that issued the access.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CORE; c++) maskReg[c] <= '1;
    end else begin
      for (int c = 0; c < NUM_CORE; c++) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (strb.coreId == CORE_W'(c) && selOh[s]) begin
            if (strb.setMask)      maskReg[c][s] <= 1'b1;
            else if (strb.clrMask) maskReg[c][s] <= 1'b0;
          end
        end
      end
    end
  end

  // Routing field per source.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) routeReg[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (strb.routeWr && selOh[s]) routeReg[s] <= strb.routeBits[NUM_CORE-1:0];
      end
    end
  end

  // Qualification: input, global enable, route bit and core mask all agree.
  always_comb begin
    for (int c = 0; c < NUM_CORE; c++) begin
      for (int s = 0; s < NUM_SRC; s++) routeCol[c][s] = routeReg[s][c];
      qual[c] = srcIn & enReg & routeCol[c] & ~maskReg[c];
    end
  end

  function automatic logic [IDX_W-1:0] lowestSet(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = NONE_PENDING;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (v[s]) r = IDX_W'(s);
    end
    return r;
  endfunction

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CORE; gc++) begin : g_core
      assign ackIdx[gc] = lowestSet(qual[gc]);

      always_ff @(posedge clk) begin
        if (rst) coreIrq[gc] <= 1'b0;
        else     coreIrq[gc] <= |qual[gc];
      end

      // R4: a mask set from this core lands on the selected source.
      a_r4_mask_set : assert property (@(posedge clk) disable iff (rst)
        (strb.setMask && idxOk && strb.coreId == CORE_W'(gc))
        |=> ((maskReg[gc] & $past(selOh)) == $past(selOh)));

      // R4: an unmask from this core clears the selected bit.
      a_r4_mask_clr : assert property (@(posedge clk) disable iff (rst)
        (strb.clrMask && idxOk && strb.coreId == CORE_W'(gc))
        |=> ((maskReg[gc] & $past(selOh)) == '0));

      // R7: a request never appears without some enabled, asserted source.
      a_r7_irq_needs_src : assert property (@(posedge clk) disable iff (rst)
        coreIrq[gc] |-> $past(|(srcIn & enReg)));
    end
  endgenerate

  // Read-side selection by core number and by source.
  always_comb begin
    ackSel = NONE_PENDING;
    for (int c = 0; c < NUM_CORE; c++) begin
      if (strb.coreId == CORE_W'(c)) ackSel = ackIdx[c];
    end
    routeRd = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (selOh[s]) routeRd = routeReg[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_INFO:  rdData <= 32'(NUM_SRC) << 2;
        RD_ACK:   rdData <= {{(32-IDX_W){1'b0}}, ackSel};
        RD_ROUTE: rdData <= {{(32-NUM_CORE){1'b0}}, routeRd};
        default:  rdData <= '0;
      endcase
    end
  end

  // R3: set-enable reaches the selected source.
  a_r3_enable_set : assert property (@(posedge clk) disable iff (rst)
    (strb.setEn && idxOk) |=> ((enReg & $past(selOh)) == $past(selOh)));

  // R3: clear-enable removes the selected source.
  a_r3_enable_clr : assert property (@(posedge clk) disable iff (rst)
    (strb.clrEn && idxOk) |=> ((enReg & $past(selOh)) == '0));

  // R6: an out-of-range number leaves every global enable alone.
  a_r6_idx_ignored : assert property (@(posedge clk) disable iff (rst)
    ((strb.setEn || strb.clrEn) && !idxOk) |=> $stable(enReg));

  // R8: the acknowledge read never reports a number past the last source.
  a_r8_ack_range : assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.rdSel == RD_ACK)
    |=> (rdData[IDX_W-1:0] == NONE_PENDING || rdData < 32'(NUM_SRC)));

endmodule

// File: rtl/dual_gate_intc.sv
module dual_gate_intc
  import dgi_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CORE = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  input  logic [1:0]          busCore,
  output logic [31:0]         busRdData,
  input  logic [NUM_SRC-1:0]  srcIn,
  output logic [NUM_CORE-1:0] coreIrq
);

  strobe_t strb;

  dgi_bus_decode #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .busWr     (busWr),
    .busRd     (busRd),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busCore   (busCore),
    .strb      (strb)
  );

  dgi_gate_core #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CORE (NUM_CORE)
  ) u_gate (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .srcIn   (srcIn),
    .coreIrq (coreIrq),
    .rdData  (busRdData)
  );

endmodule

// File: tb/tb_dual_gate_intc.sv
module tb_dual_gate_intc;

  localparam int NS = 64;
  localparam int NC = 4;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          busWr, busRd;
  logic [AW-1:0] busAddr;
  logic [31:0]   busWrData;
  logic [1:0]    busCore;
  logic [31:0]   busRdData;
  logic [NS-1:0] srcIn;
  logic [NC-1:0] coreIrq;

  int errs   = 0;
  int checks = 0;

  // Bench model built from the requirements.
  bit            enM   [NS];
  bit            maskM [NC][NS];
  logic [NC-1:0] routeM[NS];
  logic [NS-1:0] srcV;

  always #5 clk = ~clk;

  dual_gate_intc #(.NUM_SRC(NS), .NUM_CORE(NC), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busCore(busCore), .busRdData(busRdData),
    .srcIn(srcIn), .coreIrq(coreIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // All bus tasks start and end just after a falling edge.
  task automatic busWrite(int addr, logic [31:0] data, int core);
    busWr = 1'b1; busAddr = AW'(addr); busWrData = data; busCore = 2'(core);
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(int addr, int core, output logic [31:0] data);
    busRd = 1'b1; busAddr = AW'(addr); busCore = 2'(core);
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
    data = busRdData;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic int expAck(int c);
    for (int s = 0; s < NS; s++)
      if (srcV[s] && enM[s] && routeM[s][c] && !maskM[c][s]) return s;
    return 1023;
  endfunction

  // Compare IRQ outputs and every core's acknowledge value with the model.
  task automatic checkState(string req);
    logic [31:0] d;
    logic [NC-1:0] expIrq;
    settle();
    for (int c = 0; c < NC; c++) expIrq[c] = (expAck(c) != 1023);
    check({req, " irq"}, 32'(coreIrq), 32'(expIrq));
    for (int c = 0; c < NC; c++) begin
      busRead('h044, c, d);
      check({req, " ack"}, d, 32'(expAck(c)));
    end
  endtask

  task automatic enableSrc(int n);
    busWrite('h030, 32'(n), 0);
    if (n < NS) enM[n] = 1'b1;
  endtask

  task automatic disableSrc(int n);
    busWrite('h034, 32'(n), 0);
    if (n < NS) enM[n] = 1'b0;
  endtask

  task automatic maskSrc(int n, int core);
    busWrite('h048, 32'(n), core);
    if (n < NS) maskM[core][n] = 1'b1;
  endtask

  task automatic unmaskSrc(int n, int core);
    busWrite('h04C, 32'(n), core);
    if (n < NS) maskM[core][n] = 1'b0;
  endtask

  task automatic routeSrc(int n, logic [31:0] bits);
    busWrite('h100 + 4*n, bits, 0);
    if (n < NS) routeM[n] = bits[NC-1:0];
  endtask

  task automatic driveSrc(int n, logic v);
    srcV[n] = v;
    srcIn = srcV;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", 32'(coreIrq), 32'h0);
    busRead('h100 + 4*9, 0, d);
    check("R1 route zero", d, 32'h0);
    checkState("R1 idle");
    driveSrc(9, 1'b1);
    enableSrc(9);
    routeSrc(9, 32'hF);
    checkState("R1 masked by default");
  endtask

  task automatic t_info();
    logic [31:0] d;
    busRead('h000, 1, d);
    check("R2 source count", d, 32'(NS) << 2);
  endtask

  task automatic t_enable();
    unmaskSrc(9, 0);
    checkState("R3 unmasked core0");
    disableSrc(9);
    checkState("R3 global disable");
    enableSrc(9);
    checkState("R3 global re-enable");
  endtask

  task automatic t_mask();
    unmaskSrc(9, 2);
    checkState("R4 core2 unmask only");
    maskSrc(9, 2);
    checkState("R4 core2 mask, core0 kept");
  endtask

  task automatic t_route();
    logic [31:0] d;
    routeSrc(7, 32'hFFFF_FFFF);
    busRead('h100 + 4*7, 3, d);
    check("R5 route upper bits dropped", d, 32'hF);
    routeSrc(7, 32'h5);
    busRead('h100 + 4*7, 3, d);
    check("R5 route readback", d, 32'h5);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    driveSrc(0, 1'b1);
    routeSrc(0, 32'h2);
    unmaskSrc(0, 1);
    checkState("R6 setup");
    busWrite('h030, 32'(NS), 1);          // number equal to the count
    busWrite('h030, 32'h0001_0000, 1);    // high data bits set
    checkState("R6 out-of-range enable ignored");
    busWrite('h100 + 4*NS, 32'hF, 1);     // routing address past the end
    busRead('h100, 0, d);
    check("R6 route of source 0 kept", d, 32'h2);
    busWrite('h048, 32'(NS), 0);          // mask beyond range
    enableSrc(0);
    checkState("R6 source 0 still unmasked");
    disableSrc(0);
    checkState("R6 cleanup");
  endtask

  task automatic t_qualify();
    driveSrc(40, 1'b1);
    enableSrc(40);
    unmaskSrc(40, 3);
    checkState("R7 no route");
    routeSrc(40, 32'h8);
    checkState("R7 all four conditions");
    driveSrc(40, 1'b0);
    checkState("R7 input low");
    driveSrc(40, 1'b1);
    checkState("R7 input high again");
  endtask

  task automatic t_priority();
    driveSrc(12, 1'b1); driveSrc(63, 1'b1);
    enableSrc(12); enableSrc(63);
    routeSrc(12, 32'h8); routeSrc(63, 32'h8);
    unmaskSrc(12, 3); unmaskSrc(63, 3);
    checkState("R8 lowest of 12/40/63");
    maskSrc(12, 3);
    checkState("R8 next lowest");
  endtask

  task automatic t_level();
    logic [31:0] a, b;
    busRead('h044, 3, a);
    busRead('h044, 3, b);
    check("R9 repeat ack unchanged", b, a);
    check("R9 ack value", a, 32'd40);
    driveSrc(40, 1'b0);
    checkState("R9 source released");
    driveSrc(63, 1'b0);
    checkState("R9 all released");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    rst = 1'b1; busWr = 1'b0; busRd = 1'b0; busAddr = '0;
    busWrData = '0; busCore = '0; srcV = '0; srcIn = '0;
    for (int s = 0; s < NS; s++) begin
      enM[s] = 1'b0; routeM[s] = '0;
      for (int c = 0; c < NC; c++) maskM[c][s] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_info();
    t_enable();
    t_mask();
    t_route();
    t_ignore();
    t_qualify();
    t_priority();
    t_level();
    summary();
  end

endmodule